// File: doc/BRIEF.md
# I2C Slave Receiver with Per-Byte Clock Stretching

This block is the receive half of an I2C slave. It watches the bus lines, spots start and stop conditions, compares the first frame after a start with a programmable 7-bit address, records the direction bit, and then collects data bytes. Each byte is answered in the ninth clock with an acknowledge whose level is chosen by the host. When the ninth clock rises, the byte is copied into a receive buffer and the host is flagged.

When the handshake option is on, the slave holds SCL low from the falling edge of the ninth clock. It lets go only after the host has taken the byte with a read strobe. Received bytes therefore cannot be lost, however slowly the host services them. Interrupt, stop and trigger flags are cleared by a write-one-to-clear strobe from the host. The stop event can be masked so that it does not raise the interrupt flag.

The raw SCL and SDA inputs pass through a two-flop synchronizer. All edge detection runs in the system clock domain, which must be at least four times faster than SCL. The drive outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_rx_hs`

## Requirements
- R1: After reset, busy, full, all flags, scl_oe and sda_oe are 0. A start condition (SDA falls while SCL is high) sets busy. A stop condition (SDA rises while SCL is high) clears busy and sets stop_flag.
- R2: The first frame after a start holds the address in bits 7..1, sent MSB first, and the direction in bit 0. On the ninth SCL rise of a matching address frame, dir takes that bit (0 = slave receive, 1 = slave transmit).
- R3: When the address does not match own_addr, the slave leaves SDA released in the ninth clock. It sets no flag, leaves rx_data and full unchanged, and ignores all later bits until the next start.
- R4: During the ninth clock of every frame it accepts, the slave drives SDA to the value of ack_ctl: 0 pulls SDA low (ACK) and 1 leaves it released (NACK).
- R5: On the ninth SCL rise of every accepted frame, irq_flag is set. The irq output equals irq_flag AND irq_en.
- R6: On the ninth SCL rise of a data frame, the shifted byte (MSB first) appears on rx_data and full is set.
- R7: With hs_en = 1, scl_oe is asserted from the ninth SCL fall of a data frame until the host reads. With hs_en = 0, scl_oe stays 0.
- R8: A one-cycle rd_strobe clears full and releases scl_oe.
- R9: A stop condition sets irq_flag only when stop_irq_mask = 0.
- R10: When trig_en = 1, trig_flag is set together with irq_flag on the ninth SCL rise of a data frame.
- R11: A one-cycle clr_strobe clears irq_flag, stop_flag and trig_flag.
- R12: A start that arrives in the middle of a frame discards the partial bits and restarts address reception.
- R13: After an address frame with direction bit 1 has been acknowledged, the slave receives no data and leaves SDA released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| own_addr | input | 7 | Slave address to match |
| ack_ctl | input | 1 | Ninth-clock response: 0 = ACK, 1 = NACK |
| hs_en | input | 1 | Enables SCL holding after each data byte |
| stop_irq_mask | input | 1 | 1 keeps a stop from setting irq_flag |
| irq_en | input | 1 | Gates irq_flag onto irq |
| trig_en | input | 1 | Enables trig_flag on received data frames |
| rd_strobe | input | 1 | Host read of rx_data |
| clr_strobe | input | 1 | Clears irq_flag, stop_flag and trig_flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_data | output | 8 | Receive buffer |
| busy | output | 1 | Bus busy between a start and a stop |
| full | output | 1 | Receive buffer holds an unread byte |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |
| stop_flag | output | 1 | Stop condition seen |
| dir | output | 1 | Captured direction bit |
| trig_flag | output | 1 | Receive trigger flag |

## Verification
The bound checker watches these properties on every cycle:
- SCL is only ever held when handshaking is on and the buffer is full.
- A read during a hold releases the line and empties the buffer in the next cycle.
- SDA and SCL are never driven together.
- The buffer changes only while it is marked full.
- A loss of busy always comes with the stop flag.
- A masked stop never raises the interrupt flag.

Only the bench scenarios can show the values on the bus:
- the acknowledge level that a master reads back;
- an address mismatch that is ignored;
- the discarded partial frame after a repeated start;
- the silence after a read-direction address;
- the exact byte that reaches the buffer.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ADDR = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic               ackph;
        logic [FRAME_W-1:0] sh;
        logic [FRAME_W-1:0] rx;
        logic               full;
        logic               busy;
        logic               irqf;
        logic               stopf;
        logic               dir;
        logic               trig;
        logic               sda_oe;
        logic               scl_oe;
    } rx_regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= {ff_q[STAGES-2:0], d};
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign ev_start = scl && scl_q && sda_q && !sda;
    assign ev_stop  = scl && scl_q && !sda_q && sda;
    assign ev_rise  = scl && !scl_q;
    assign ev_fall  = !scl && scl_q;
endmodule

// File: rtl/i2c_rx_hs.sv
module i2c_rx_hs #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    input  logic [i2c_rx_pkg::ADDR_W-1:0] own_addr,
    input  logic                          ack_ctl,
    input  logic                          hs_en,
    input  logic                          stop_irq_mask,
    input  logic                          irq_en,
    input  logic                          trig_en,
    input  logic                          rd_strobe,
    input  logic                          clr_strobe,
    output logic                          scl_oe,
    output logic                          sda_oe,
    output logic [i2c_rx_pkg::FRAME_W-1:0] rx_data,
    output logic                          busy,
    output logic                          full,
    output logic                          irq_flag,
    output logic                          irq,
    output logic                          stop_flag,
    output logic                          dir,
    output logic                          trig_flag
);
    import i2c_rx_pkg::*;

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, syn_lines;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    rx_regs_t q, d;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lines[g]),
            .q    (syn_lines[g])
        );
    end

    i2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (syn_lines[0]),
        .sda     (syn_lines[1]),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    always_comb begin
        d = q;
        if (clr_strobe) begin
            d.irqf  = 1'b0;
            d.stopf = 1'b0;
            d.trig  = 1'b0;
        end
        if (rd_strobe) begin
            d.full   = 1'b0;
            d.scl_oe = 1'b0;
        end
        if (ev_start) begin
            d.busy   = 1'b1;
            d.st     = RX_ADDR;
            d.cnt    = '0;
            d.ackph  = 1'b0;
            d.sda_oe = 1'b0;
        end else if (ev_stop) begin
            d.busy   = 1'b0;
            d.stopf  = 1'b1;
            if (!stop_irq_mask) d.irqf = 1'b1;
            d.st     = RX_IDLE;
            d.cnt    = '0;
            d.ackph  = 1'b0;
            d.sda_oe = 1'b0;
        end else if (q.st != RX_IDLE) begin
            if (ev_rise) begin
                if (!q.ackph) begin
                    d.sh  = {q.sh[FRAME_W-2:0], syn_lines[1]};
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.irqf = 1'b1;
                    if (q.st == RX_ADDR) begin
                        d.dir = q.sh[0];
                    end else begin
                        d.rx   = q.sh;
                        d.full = 1'b1;
                        if (trig_en) d.trig = 1'b1;
                    end
                end
            end else if (ev_fall) begin
                if (!q.ackph && q.cnt == CNT_W'(FRAME_W)) begin
                    if (q.st == RX_ADDR && q.sh[FRAME_W-1:1] != own_addr) begin
                        d.st = RX_IDLE;
                    end else begin
                        d.ackph  = 1'b1;
                        d.sda_oe = !ack_ctl;
                    end
                end else if (q.ackph) begin
                    d.ackph  = 1'b0;
                    d.sda_oe = 1'b0;
                    d.cnt    = '0;
                    if (q.st == RX_ADDR) begin
                        d.st = q.dir ? RX_IDLE : RX_DATA;
                    end else if (hs_en && d.full) begin
                        d.scl_oe = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
    assign rx_data   = q.rx;
    assign busy      = q.busy;
    assign full      = q.full;
    assign irq_flag  = q.irqf;
    assign irq       = q.irqf & irq_en;
    assign stop_flag = q.stopf;
    assign dir       = q.dir;
    assign trig_flag = q.trig;
endmodule

// File: rtl/i2c_rx_hs_chk.sv
module i2c_rx_hs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_en,
    input logic       stop_irq_mask,
    input logic       rd_strobe,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] rx_data,
    input logic       busy,
    input logic       full,
    input logic       irq_flag,
    input logic       stop_flag
);
    // R7: holding only begins with handshaking on and a byte waiting
    assert_hold_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> (full && hs_en));

    // R8: a read during a hold releases SCL and empties the buffer
    assert_read_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && scl_oe) |=> (!scl_oe && !full));

    // R4: SDA is never pulled while SCL is held
    assert_no_dual_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);

    // R6: the buffer only changes together with full
    assert_buffer_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> full);

    // R1: busy only drops on a stop
    assert_busy_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> stop_flag);

    // R9: a masked stop leaves the interrupt flag alone
    assert_stop_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_flag) && stop_irq_mask && !$past(irq_flag)) |-> !irq_flag);
endmodule

bind i2c_rx_hs i2c_rx_hs_chk u_chk (.*);

// File: tb/test_i2c_rx_hs.sv
module test_i2c_rx_hs;
    localparam int HALF = 8;
    localparam logic [6:0] OWN = 7'h5A;

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] data;
        logic       ackc;
        logic       hs;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{addr: 7'h5A, data: 8'hA5, ackc: 1'b0, hs: 1'b1},
        '{addr: 7'h5A, data: 8'h3C, ackc: 1'b1, hs: 1'b0},
        '{addr: 7'h22, data: 8'hFF, ackc: 1'b0, hs: 1'b1},
        '{addr: 7'h5A, data: 8'h00, ackc: 1'b0, hs: 1'b0},
        '{addr: 7'h5B, data: 8'h81, ackc: 1'b0, hs: 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_i, sda_i;
    logic [6:0] own_addr = OWN;
    logic ack_ctl = 1'b0, hs_en = 1'b0, stop_irq_mask = 1'b1;
    logic irq_en = 1'b1, trig_en = 1'b0, rd_strobe = 1'b0, clr_strobe = 1'b0;
    logic scl_oe, sda_oe, busy, full, irq_flag, irq, stop_flag, dir, trig_flag;
    logic [7:0] rx_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_i = scl_m & ~scl_oe;
    assign sda_i = sda_m & ~sda_oe;

    i2c_rx_hs i_i2c_rx_hs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .own_addr(own_addr), .ack_ctl(ack_ctl), .hs_en(hs_en),
        .stop_irq_mask(stop_irq_mask), .irq_en(irq_en), .trig_en(trig_en),
        .rd_strobe(rd_strobe), .clr_strobe(clr_strobe),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .busy(busy),
        .full(full), .irq_flag(irq_flag), .irq(irq), .stop_flag(stop_flag),
        .dir(dir), .trig_flag(trig_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(2);
        sda_m = 1'b1;
        tick(HALF);
        scl_m = 1'b1;
        while (!scl_i) tick(1);
        tick(HALF);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b1;
        while (!scl_i) tick(1);
        tick(HALF);
        sda_m = 1'b1;
        tick(HALF);
    endtask

    task automatic send_bit(input logic v);
        tick(2);
        sda_m = v;
        tick(HALF);
        scl_m = 1'b1;
        while (!scl_i) tick(1);
        tick(HALF);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackv);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(2);
        sda_m = 1'b1;
        tick(HALF);
        scl_m = 1'b1;
        while (!scl_i) tick(1);
        tick(HALF / 2);
        ackv = sda_i;
        tick(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_strobe = 1'b1;
        tick(1);
        clr_strobe = 1'b0;
        tick(1);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        tick(1);
    endtask

    initial begin
        logic a;
        logic [7:0] exp_rx;
        logic match;
        exp_rx = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        chk("R1 reset busy", busy, 0);
        chk("R1 reset full", full, 0);
        chk("R1 reset flags", {irq_flag, stop_flag, trig_flag}, 0);
        chk("R1 reset drives", {scl_oe, sda_oe}, 0);

        foreach (VECS[k]) begin
            ack_ctl = VECS[k].ackc;
            hs_en = VECS[k].hs;
            stop_irq_mask = 1'b1;
            match = (VECS[k].addr == OWN);
            bus_start();
            tick(4);
            chk("R1 start sets busy", busy, 1);
            send_byte({VECS[k].addr, 1'b0}, a);
            chk(match ? "R4 address ack level" : "R3 mismatch sda released", a,
                match ? VECS[k].ackc : 1'b1);
            tick(1);
            if (match) begin
                chk("R5 irq_flag after address", irq_flag, 1);
                chk("R2 dir write", dir, 0);
            end else begin
                chk("R3 mismatch no irq", irq_flag, 0);
            end
            pulse_clr();
            send_byte(VECS[k].data, a);
            tick(6);
            if (match) begin
                exp_rx = VECS[k].data;
                chk("R4 data ack level", a, VECS[k].ackc);
                chk("R6 rx_data", rx_data, exp_rx);
                chk("R6 full set", full, 1);
                chk("R7 scl hold follows hs_en", scl_oe, VECS[k].hs);
                chk("R5 irq_flag after data", irq_flag, 1);
                pulse_rd();
                chk("R8 read clears full", full, 0);
                chk("R8 read releases scl", scl_oe, 0);
            end else begin
                chk("R3 mismatch data not acked", a, 1);
                chk("R3 mismatch full unchanged", full, 0);
                chk("R3 mismatch rx_data unchanged", rx_data, exp_rx);
                chk("R3 mismatch no irq", irq_flag, 0);
                chk("R3 mismatch no scl hold", scl_oe, 0);
            end
            pulse_clr();
            bus_stop();
            tick(4);
            chk("R1 stop clears busy", busy, 0);
            chk("R1 stop sets stop_flag", stop_flag, 1);
            chk("R9 masked stop no irq", irq_flag, 0);
            pulse_clr();
        end

        // R9 unmasked stop
        stop_irq_mask = 1'b0;
        bus_start();
        bus_stop();
        tick(4);
        chk("R9 unmasked stop irq", irq_flag, 1);
        chk("R9 stop_flag", stop_flag, 1);
        pulse_clr();
        chk("R11 clear irq and stop", {irq_flag, stop_flag}, 0);
        stop_irq_mask = 1'b1;

        // R10 trigger flag and R5 irq gating
        trig_en = 1'b1;
        hs_en = 1'b0;
        ack_ctl = 1'b0;
        bus_start();
        send_byte({OWN, 1'b0}, a);
        tick(1);
        chk("R10 no trigger on address", trig_flag, 0);
        pulse_clr();
        send_byte(8'h77, a);
        tick(4);
        chk("R10 trigger set", trig_flag, 1);
        chk("R5 irq with enable", irq, 1);
        irq_en = 1'b0;
        tick(1);
        chk("R5 irq gated off", irq, 0);
        irq_en = 1'b1;
        pulse_clr();
        chk("R11 clear trigger", {trig_flag, irq_flag}, 0);
        pulse_rd();
        bus_stop();
        pulse_clr();
        trig_en = 1'b0;

        // R13 read direction then ignore
        hs_en = 1'b1;
        bus_start();
        send_byte({OWN, 1'b1}, a);
        chk("R13 read address acked", a, 0);
        tick(1);
        chk("R2 dir read", dir, 1);
        pulse_clr();
        send_byte(8'h12, a);
        tick(6);
        chk("R13 no ack after read address", a, 1);
        chk("R13 no data received", full, 0);
        chk("R13 no scl hold", scl_oe, 0);
        bus_stop();
        pulse_clr();

        // R12 repeated start mid-frame
        bus_start();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R12 address acked after restart", a, 0);
        send_byte(8'h99, a);
        tick(6);
        chk("R12 byte after restart", rx_data, 8'h99);
        chk("R12 hold after restart", scl_oe, 1);
        pulse_rd();
        bus_stop();
        pulse_clr();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule